// File: doc/BRIEF.md
# Soft Shutdown Sequencer

This block halts an audio processing core quietly so that its coefficient and program memories can be rewritten without an audible pop. A host raises a shutdown request. The sequencer then fades the output gain to zero, one step per audio frame. Only when the gain reaches zero does it halt the core and raise a status flag. The host may poll that flag, or it may wait longer than the worst-case fade time. With the default of 512 steps at a 48 kHz frame rate, the fade lasts about 10.7 ms, which falls inside the 10 ms to 20 ms window.

While the core is halted, a burst port passes host accesses straight to memory. A start strobe loads an address. Each data word, whether a read or a write, goes to the current address, and the address then advances by one. When the host drops the request, the core restarts at once and the gain fades back up to unity. If the host drops the request part-way through the fade-out, the gain turns round from its current level without halting the core. The gain multiplier and the serial host link sit outside this block.

Top module: `fade_halt_seq`

## Requirements
- R1: After reset, gain_out equals unity (1 << FRAC_W), core_run is 1, halted is 0 and mem_en is 0.
- R2: While shutdown is requested, gain_out falls by exactly STEP = (1 << FRAC_W) / RAMP_STEPS on each frame_tick until it reaches zero. A fade from unity takes RAMP_STEPS frame ticks.
- R3: core_run falls and halted rises together, and only after gain_out has reached zero. halted is 1 only while the core is halted, and gain_out is zero throughout that time.
- R4: While halted, host_start loads host_addr. Each host_valid access uses the current address, which then increments modulo 2^ADDR_W.
- R5: When host_start and host_valid are high in the same cycle, the access uses the newly loaded host_addr, and the next address is host_addr + 1.
- R6: Outside the halted state, host_start and host_valid are ignored: mem_en stays 0 and the address pointer keeps its value.
- R7: Clearing shutdown_req while halted makes core_run 1 and halted 0 on the next cycle. The gain then rises by STEP per frame tick back to unity.
- R8: Clearing shutdown_req during the fade-out reverses the ramp from the current gain, and halted never rises.
- R9: gain_out changes only in the cycle after a frame_tick, and each change is exactly one STEP.
- R10: An accepted access drives mem_we equal to host_write (1 means write, 0 means read), and mem_wdata carries host_wdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shutdown_req | input | 1 | Host request to halt the core (level) |
| frame_tick | input | 1 | One-cycle pulse per audio frame; paces the ramps |
| gain_out | output | GAIN_W | Gain coefficient, FRAC_W fractional bits |
| core_run | output | 1 | High while the processing core may run |
| halted | output | 1 | Status: shutdown complete, memories open to the host |
| host_start | input | 1 | Load the burst start address |
| host_addr | input | ADDR_W | Burst start address |
| host_valid | input | 1 | One data-word access in this cycle |
| host_write | input | 1 | 1 = write, 0 = read for this access |
| host_wdata | input | DATA_W | Write data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |

## Verification
Two functions can meet in one cycle: loading a burst address and issuing a data word. The bench drives host_start and host_valid together while the core is halted. The scoreboard expects that access at the new address and the following word at the new address plus one. Release of the request can also coincide with a frame tick and with a final word while still halted. The bench checks that this word is still accepted, and that the core restarts on the next cycle.

// File: rtl/fhs_pkg.sv
// Shared types for the soft shutdown sequencer.
package fhs_pkg;
    // Sequencer states; the order carries no meaning.
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_RAMP_DOWN = 2'd1,
        ST_HALTED    = 2'd2,
        ST_RAMP_UP   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/fhs_fsm.sv
// Sequencer state machine.
// Assumes at_zero/at_full come from the ramp level register of this cycle.
module fhs_fsm
    import fhs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shutdown_req,
    input  logic       at_zero,
    input  logic       at_full,
    output seq_state_t state
);
    seq_state_t state_nx;

    // Next-state selection from request level and ramp end points.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:       if (shutdown_req) state_nx = ST_RAMP_DOWN;
            ST_RAMP_DOWN: if (!shutdown_req) state_nx = ST_RAMP_UP;
                          else if (at_zero)  state_nx = ST_HALTED;
            ST_HALTED:    if (!shutdown_req) state_nx = ST_RAMP_UP;
            ST_RAMP_UP:   if (shutdown_req)  state_nx = ST_RAMP_DOWN;
                          else if (at_full)  state_nx = ST_RUN;
            default:      state_nx = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end
endmodule

// File: rtl/fhs_ramp.sv
// Gain ramp: a level counter 0..RAMP_STEPS, moved one step per frame tick,
// scaled to a fixed-point coefficient. Assumes (1<<FRAC_W) divisible by RAMP_STEPS.
module fhs_ramp
    import fhs_pkg::*;
#(
    parameter int GAIN_W     = 22,
    parameter int FRAC_W     = 20,
    parameter int RAMP_STEPS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    input  logic              frame_tick,
    output logic [GAIN_W-1:0] gain_out,
    output logic              at_zero,
    output logic              at_full
);
    localparam int LVL_W = $clog2(RAMP_STEPS + 1);
    localparam int UNITY = 1 << FRAC_W;
    localparam int STEP  = UNITY / RAMP_STEPS;
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(RAMP_STEPS);

    logic [LVL_W-1:0] level;

    // End-point flags for the state machine.
    always_comb begin
        at_zero = (level == '0);
        at_full = (level == LVL_MAX);
    end

    // Level counter: down during fade-out, up during fade-in, on frame ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= LVL_MAX;
        end else if (frame_tick) begin
            if (state == ST_RAMP_DOWN && !at_zero)
                level <= level - 1'b1;
            else if (state == ST_RAMP_UP && !at_full)
                level <= level + 1'b1;
        end
    end

    // Scale the level to the coefficient format.
    always_comb gain_out = GAIN_W'(level) * GAIN_W'(STEP);
endmodule

// File: rtl/fhs_burst.sv
// Burst memory port: start strobe loads an address, each access uses it and
// advances it. Assumes halted is the registered status of this cycle.
module fhs_burst #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halted,
    input  logic              host_start,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    logic [ADDR_W-1:0] addr_q;
    logic              load_ok;

    // Address for this cycle: a fresh start address wins over the pointer.
    always_comb begin
        load_ok   = halted && host_start;
        mem_addr  = load_ok ? host_addr : addr_q;
        mem_en    = halted && host_valid;
        mem_we    = mem_en && host_write;
        mem_wdata = host_wdata;
    end

    // Pointer: advance past an accepted access, else take a start address.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (mem_en) addr_q <= mem_addr + 1'b1;
        else if (load_ok) addr_q <= host_addr;
    end
endmodule

// File: rtl/fade_halt_seq.sv
// Soft shutdown sequencer top: fades gain to zero, halts the core, opens a
// burst memory port while halted, and fades back in on release.
// Assumes frame_tick is a one-cycle pulse at the audio frame rate.
module fade_halt_seq
    import fhs_pkg::*;
#(
    parameter int GAIN_W     = 22,
    parameter int FRAC_W     = 20,
    parameter int RAMP_STEPS = 512,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shutdown_req,
    input  logic              frame_tick,
    output logic [GAIN_W-1:0] gain_out,
    output logic              core_run,
    output logic              halted,
    input  logic              host_start,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    seq_state_t state;
    logic       at_zero;
    logic       at_full;

    fhs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .shutdown_req (shutdown_req),
        .at_zero      (at_zero),
        .at_full      (at_full),
        .state        (state)
    );

    fhs_ramp #(
        .GAIN_W     (GAIN_W),
        .FRAC_W     (FRAC_W),
        .RAMP_STEPS (RAMP_STEPS)
    ) u_ramp (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .frame_tick (frame_tick),
        .gain_out   (gain_out),
        .at_zero    (at_zero),
        .at_full    (at_full)
    );

    // Status and core enable decoded from the state.
    always_comb begin
        halted   = (state == ST_HALTED);
        core_run = (state != ST_HALTED);
    end

    fhs_burst #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .halted     (halted),
        .host_start (host_start),
        .host_addr  (host_addr),
        .host_valid (host_valid),
        .host_write (host_write),
        .host_wdata (host_wdata),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );
endmodule

// File: rtl/fhs_checker.sv
// Temporal checks on the sequencer ports, bound into every instance.
module fhs_checker #(
    parameter int GAIN_W     = 22,
    parameter int FRAC_W     = 20,
    parameter int RAMP_STEPS = 512,
    parameter int ADDR_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shutdown_req,
    input logic              frame_tick,
    input logic [GAIN_W-1:0] gain_out,
    input logic              core_run,
    input logic              halted,
    input logic              host_start,
    input logic              mem_en,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam logic [GAIN_W-1:0] STEP = GAIN_W'((1 << FRAC_W) / RAMP_STEPS);

    assert_halt_gain_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> gain_out == '0);

    assert_halt_after_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(gain_out) == '0);

    assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(gain_out));

    assert_one_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> (gain_out == $past(gain_out)) ||
                       (gain_out == $past(gain_out) - STEP) ||
                       (gain_out == $past(gain_out) + STEP));

    assert_addr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> (halted && host_start) || mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

    assert_ignore_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> (halted && host_start) || $stable(mem_addr));

    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !shutdown_req) |=> (core_run && !halted));

    assert_no_halt_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !shutdown_req |=> !$rose(halted));
endmodule

bind fade_halt_seq fhs_checker #(
    .GAIN_W     (GAIN_W),
    .FRAC_W     (FRAC_W),
    .RAMP_STEPS (RAMP_STEPS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .shutdown_req (shutdown_req),
    .frame_tick   (frame_tick),
    .gain_out     (gain_out),
    .core_run     (core_run),
    .halted       (halted),
    .host_start   (host_start),
    .mem_en       (mem_en),
    .mem_addr     (mem_addr)
);

// File: tb/fade_halt_seq_tb.sv
// Scoreboard bench: driver tasks queue expected memory accesses, a monitor
// pops and compares them; gain steps are watched continuously.
module fade_halt_seq_tb;
    localparam int GAIN_W = 22;
    localparam int FRAC_W = 20;
    localparam int STEPS  = 16;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 22;
    localparam int TICK_P = 4;
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << FRAC_W);
    localparam logic [GAIN_W-1:0] STEP  = GAIN_W'((1 << FRAC_W) / STEPS);

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } acc_t;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              shutdown_req = 0;
    logic              frame_tick = 0;
    logic [GAIN_W-1:0] gain_out;
    logic              core_run, halted;
    logic              host_start = 0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic              host_valid = 0;
    logic              host_write = 0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic              mem_en, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;
    bit   seen_halt = 0;
    acc_t exp_q[$];

    fade_halt_seq #(
        .GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .RAMP_STEPS(STEPS),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .shutdown_req(shutdown_req), .frame_tick(frame_tick),
        .gain_out(gain_out), .core_run(core_run), .halted(halted),
        .host_start(host_start), .host_addr(host_addr), .host_valid(host_valid),
        .host_write(host_write), .host_wdata(host_wdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Free-running frame tick, one cycle in TICK_P.
    initial begin
        forever begin
            repeat (TICK_P - 1) @(posedge clk);
            #1 frame_tick = 1;
            @(posedge clk);
            #1 frame_tick = 0;
        end
    end

    // Monitor: scoreboard pops and gain step rule (R9, R2).
    logic [GAIN_W-1:0] prev_gain;
    logic              prev_tick = 0;
    initial begin
        @(posedge rst_n);
        @(negedge clk);
        prev_gain = gain_out;
        forever begin
            @(negedge clk);
            if (halted) seen_halt = 1;
            if (gain_out != prev_gain) begin
                check(prev_tick, "R9", "gain moved without tick", 0, 1);
                check(gain_out == prev_gain - STEP || gain_out == prev_gain + STEP,
                      "R2", "gain step size", gain_out, prev_gain);
            end
            prev_gain = gain_out;
            prev_tick = frame_tick;
            if (mem_en) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6", "unexpected access addr", mem_addr, 0);
                end else begin
                    acc_t e;
                    e = exp_q.pop_front();
                    check(mem_addr == e.addr, "R4", "access addr", mem_addr, e.addr);
                    check(mem_we == e.we, "R10", "write enable", mem_we, e.we);
                    if (e.we)
                        check(mem_wdata == e.data, "R10", "write data", mem_wdata, e.data);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        check(0, "WDOG", "watchdog expired", 0, 1);
        summary();
    end

    // Driver: one host cycle; queues the expected access when accepted.
    task automatic host_cycle(input bit start, input logic [ADDR_W-1:0] a,
                              input bit valid, input bit we, input logic [DATA_W-1:0] d,
                              input bit expect_acc, input logic [ADDR_W-1:0] exp_addr);
        @(posedge clk); #1;
        host_start = start; host_addr = a; host_valid = valid;
        host_write = we; host_wdata = d;
        if (expect_acc) exp_q.push_back('{we: we, addr: exp_addr, data: d});
        @(negedge clk);
        if (!expect_acc) check(mem_en == 1'b0, "R6", "access outside halt", mem_en, 0);
        @(posedge clk); #1;
        host_start = 0; host_valid = 0; host_write = 0;
    endtask

    task automatic wait_halted(output int cycles);
        cycles = 0;
        while (!halted && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic wait_unity(output int cycles);
        cycles = 0;
        while (gain_out != UNITY && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    initial begin
        int cyc;
        logic [GAIN_W-1:0] g_rel;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(gain_out == UNITY, "R1", "reset gain", gain_out, UNITY);
        check(core_run == 1'b1, "R1", "reset core_run", core_run, 1);
        check(halted == 1'b0, "R1", "reset halted", halted, 0);
        check(mem_en == 1'b0, "R1", "reset mem_en", mem_en, 0);

        // R6: start and word while running are ignored
        host_cycle(1, 8'h55, 1, 1, 22'h1234, 0, '0);

        // R2/R3: fade-out then halt
        @(posedge clk); #1 shutdown_req = 1;
        @(negedge clk);
        wait_halted(cyc);
        check(halted == 1'b1, "R3", "halted reached", halted, 1);
        check(cyc >= STEPS * TICK_P - TICK_P && cyc <= STEPS * TICK_P + 2 * TICK_P,
              "R2", "fade length cycles", cyc, STEPS * TICK_P);
        check(gain_out == '0, "R3", "gain at halt", gain_out, 0);
        check(core_run == 1'b0, "R3", "core stopped", core_run, 0);

        // R6 continued: pointer kept reset value, not 0x55
        host_cycle(0, '0, 1, 1, 22'h00AAA, 1, 8'h00);
        // R5: start and word together
        host_cycle(1, 8'h10, 1, 1, 22'h3FFFF, 1, 8'h10);
        host_cycle(0, '0, 1, 1, 22'h00001, 1, 8'h11);
        host_cycle(0, '0, 1, 0, 22'h0, 1, 8'h12);
        // R4: start alone, then wrap
        host_cycle(1, 8'hFE, 0, 0, 22'h0, 0, '0);
        host_cycle(0, '0, 1, 1, 22'h2A2A2, 1, 8'hFE);
        host_cycle(0, '0, 1, 1, 22'h15151, 1, 8'hFF);
        host_cycle(0, '0, 1, 0, 22'h0, 1, 8'h00);
        check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);

        // R7: release, final word in same cycle still accepted
        @(posedge clk); #1;
        shutdown_req = 0; host_valid = 1; host_write = 1; host_wdata = 22'h0BEEF;
        exp_q.push_back('{we: 1'b1, addr: 8'h01, data: 22'h0BEEF});
        @(negedge clk);
        check(halted == 1'b1, "R7", "still halted in release cycle", halted, 1);
        @(posedge clk); #1 host_valid = 0; host_write = 0;
        @(negedge clk);
        check(halted == 1'b0, "R7", "halted cleared", halted, 0);
        check(core_run == 1'b1, "R7", "core restarted", core_run, 1);
        wait_unity(cyc);
        check(gain_out == UNITY, "R7", "gain back to unity", gain_out, UNITY);
        check(exp_q.size() == 0, "R5", "release-cycle word taken", exp_q.size(), 0);

        // R6 during run: ignored, pointer continues at 0x02 later
        host_cycle(1, 8'h77, 1, 0, 22'h0, 0, '0);

        // R8: abort mid fade-out
        seen_halt = 0;
        @(posedge clk); #1 shutdown_req = 1;
        repeat (6 * TICK_P) @(negedge clk);
        @(posedge clk); #1 shutdown_req = 0;
        @(negedge clk);
        g_rel = gain_out;
        check(g_rel != '0 && g_rel < UNITY, "R8", "gain mid-fade", g_rel, UNITY - 6 * STEP);
        wait_unity(cyc);
        check(gain_out == UNITY, "R8", "reversed to unity", gain_out, UNITY);
        check(seen_halt == 1'b0, "R8", "never halted", seen_halt, 0);
        check(core_run == 1'b1, "R8", "core kept running", core_run, 1);

        // R6: pointer unchanged by ignored start 0x77
        @(posedge clk); #1 shutdown_req = 1;
        @(negedge clk);
        wait_halted(cyc);
        host_cycle(0, '0, 1, 1, 22'h00777, 1, 8'h02);
        check(exp_q.size() == 0, "R6", "pointer kept across run", exp_q.size(), 0);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule